// File: doc/BRIEF.md
# Self-Correcting One-Hot Ring Counter

This block is an N-stage counter whose state carries exactly one set bit. On each enabled clock, that bit advances one stage toward the most significant position. From the top stage it returns to stage 0, so the pattern repeats every N enabled clocks. Logic that needs N mutually exclusive phases uses it as a phase generator or as a state-encoding source. A single-cycle wrap flag marks the enabled clock on which the hot bit leaves the top stage.

The ring does not feed the top stage straight back into stage 0. Instead, stage 0 loads a 1 only when every stage except the top one is clear. This gives the counter a self-starting property. An all-zero register reloads the start pattern on the next enabled edge. Surplus 1s shift out of the top and are never replaced. As a result, any corrupted pattern settles into the legal one-hot cycle within N enabled clocks, with no reset needed. A synchronous active-high reset restores the start pattern and overrides the enable.

Top module: `ring_onehot_ctr`

## Requirements
- R1: On a clock edge with reset high, the state becomes the start pattern: bit 0 set and all other bits clear (0001 for N=4).
- R2: With reset low and enable high, starting from a legal state, bit i+1 takes the old bit i on each edge. The sequence for N=4 is 0001, 0010, 0100, 1000, 0001, with period N.
- R3: With reset low and enable low, the state does not change on the clock edge.
- R4: Reset takes priority over enable. When both are high, the next state is the start pattern, not the advanced one.
- R5: An all-zero state with enable high becomes the start pattern on the next edge, without reset.
- R6: On an enabled edge, bit 0 is loaded with the NOR of bits 0 to N-2. The upper bits shift up by one, so 1s that leave the top are not refilled.
- R7: From any of the 2^N states, at most N enabled edges bring the state to a one-hot value. After that it stays one-hot and follows the R2 order.
- R8: wrap_o is a combinational flag. It is 1 exactly when reset is low, enable is high and the state is the top-only pattern (1000 for N=4), and 0 in every other case. The edge that follows a 1 on wrap_o loads the start pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high; loads the start pattern |
| en_i | input | 1 | Count enable; low holds the state |
| state_o | output | N | Current counter state, one-hot in the legal cycle |
| wrap_o | output | 1 | High while the enabled edge will move the hot bit from the top stage to stage 0 |

## Verification
Two things can coincide in one cycle: a wrap and a reset. The bench provokes this by raising reset, with enable still high, while the state sits at the top-only pattern. The correct result is that wrap_o reads 0 in that cycle and the state becomes the start pattern, not an advanced or recovered value. Recovery and wrap can also meet, for example when 1000-like tails of corrupted patterns reach the top. In those cycles the bench judges wrap_o only against the exact top-only pattern, so a tail that still carries extra 1s must not flag a wrap.

// File: rtl/ring_pkg.sv
package ring_pkg;

    typedef struct packed {
        logic rst;
        logic en;
    } ring_ctrl_t;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_ADVANCE = 2'd1,
        ACT_RESTART = 2'd2
    } ring_act_e;

    function automatic ring_act_e pick_action(ring_ctrl_t c);
        if (c.rst) return ACT_RESTART;
        if (c.en)  return ACT_ADVANCE;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/ring_feedback.sv
module ring_feedback #(
    parameter int N = 4
) (
    input  logic [N-1:0] cur_i,
    output logic [N-1:0] nxt_o
);
    localparam int LOW_W = N - 1;

    logic [LOW_W-1:0] low_bits;
    assign low_bits = cur_i[LOW_W-1:0];

    // stage 0: recovery decode over all stages except the top one
    assign nxt_o[0] = ~|low_bits;

    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_shift
            assign nxt_o[g] = cur_i[g-1];
        end
    endgenerate
endmodule

// File: rtl/ring_stage_reg.sv
module ring_stage_reg
    import ring_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  ring_act_e    act_i,
    input  logic [N-1:0] nxt_i,
    output logic [N-1:0] state_o
);
    localparam logic [N-1:0] START = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] state_q;

    always_ff @(posedge clk_i) begin
        unique case (act_i)
            ACT_RESTART: state_q <= START;
            ACT_ADVANCE: state_q <= nxt_i;
            default:     state_q <= state_q;
        endcase
    end

    assign state_o = state_q;

    // R4: reset beats enable
    p_reset_wins_r4: assert property (@(posedge clk_i)
        (rst_i && en_i) |=> (state_q == START));

    // R3: disabled count holds
    p_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(state_q));
endmodule

// File: rtl/ring_wrap_detect.sv
module ring_wrap_detect
    import ring_pkg::*;
#(
    parameter int N = 4
) (
    input  ring_act_e    act_i,
    input  logic [N-1:0] cur_i,
    output logic         wrap_o
);
    localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};

    assign wrap_o = (act_i == ACT_ADVANCE) && (cur_i == TOP);
endmodule

// File: rtl/ring_onehot_ctr.sv
module ring_onehot_ctr
    import ring_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    output logic [N-1:0] state_o,
    output logic         wrap_o
);
    localparam logic [N-1:0] START = {{(N-1){1'b0}}, 1'b1};
    localparam int CW = $clog2(N + 2);

    ring_ctrl_t   ctrl;
    ring_act_e    act;
    logic [N-1:0] cur;
    logic [N-1:0] nxt;

    assign ctrl.rst = rst_i;
    assign ctrl.en  = en_i;
    assign act      = pick_action(ctrl);

    ring_feedback #(.N(N)) u_fb (
        .cur_i (cur),
        .nxt_o (nxt)
    );

    ring_stage_reg #(.N(N)) u_reg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .act_i   (act),
        .nxt_i   (nxt),
        .state_o (cur)
    );

    ring_wrap_detect #(.N(N)) u_wrap (
        .act_i  (act),
        .cur_i  (cur),
        .wrap_o (wrap_o)
    );

    assign state_o = cur;

    // count of consecutive enabled edges spent in a non-one-hot state
    logic [CW-1:0] bad_cnt_q;
    always_ff @(posedge clk_i) begin
        if (rst_i || ($countones(cur) == 1))
            bad_cnt_q <= '0;
        else if (en_i && (bad_cnt_q != CW'(N + 1)))
            bad_cnt_q <= bad_cnt_q + 1'b1;
    end

    p_shift_up_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (cur[N-1:1] == $past(cur[N-2:0])));

    p_zero_recover_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && (cur == '0)) |=> (cur == START));

    p_clear_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && (|cur[N-2:0])) |=> !cur[0]);

    p_onehot_kept_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && ($countones(cur) == 1)) |=> ($countones(cur) == 1));

    p_recover_bound_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        bad_cnt_q <= CW'(N));

    p_wrap_next_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> (cur == START));
endmodule

// File: tb/sim_ring_onehot_ctr.sv
`timescale 1ns/1ps
module sim_ring_onehot_ctr;
    localparam int N = 4;
    localparam logic [N-1:0] START = 4'b0001;
    localparam logic [N-1:0] TOP   = 4'b1000;

    logic         clk = 1'b0;
    logic         rst;
    logic         en;
    logic [N-1:0] state;
    logic         wrap;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ring_onehot_ctr #(.N(N)) u0 (
        .clk_i   (clk),
        .rst_i   (rst),
        .en_i    (en),
        .state_o (state),
        .wrap_o  (wrap)
    );

    // expected next state from R6 (which covers R2/R5)
    function automatic logic [N-1:0] model_next(logic [N-1:0] s);
        return {s[N-2:0], ~|s[N-2:0]};
    endfunction

    function automatic logic model_wrap(logic r, logic e, logic [N-1:0] s);
        return !r && e && (s == TOP);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] exp_s;
        logic         seen_legal;
        void'($urandom(32'd1234));
        rst = 1'b1;
        en  = 1'b0;
        @(negedge clk);
        step();
        step();
        chk("R1 reset value", state, START);
        chk("R8 no wrap in reset", wrap, 1'b0);

        // legal rotation with wrap flag
        rst = 1'b0;
        en  = 1'b1;
        exp_s = START;
        for (int i = 0; i < 2 * N; i++) begin
            #1;
            chk("R8 wrap flag", wrap, model_wrap(rst, en, exp_s));
            step();
            exp_s = model_next(exp_s);
            chk("R2 rotation", state, exp_s);
        end

        // hold with enable low
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R8 no wrap when disabled", wrap, 1'b0);
            step();
            chk("R3 hold", state, exp_s);
        end

        // walk to top, then reset together with enable at the wrap point
        en = 1'b1;
        while (state != TOP) step();
        #1;
        chk("R8 wrap at top", wrap, 1'b1);
        rst = 1'b1;
        #1;
        chk("R4 R8 reset masks wrap", wrap, 1'b0);
        step();
        chk("R4 reset wins over enable", state, START);
        rst = 1'b0;

        // every one of the 2^N start states
        for (int s = 0; s < (1 << N); s++) begin
            rst = 1'b1;
            en  = 1'b0;
            step();
            force u0.u_reg.state_q = s[N-1:0];
            step();
            release u0.u_reg.state_q;
            rst = 1'b0;
            en  = 1'b1;
            #1;
            chk("R7 forced load", state, s[N-1:0]);
            exp_s = s[N-1:0];
            seen_legal = ($countones(exp_s) == 1);
            for (int k = 0; k < N; k++) begin
                chk("R8 wrap during recovery", wrap, model_wrap(rst, en, exp_s));
                step();
                exp_s = model_next(exp_s);
                if (s == 0 && k == 0)
                    chk("R5 zero restart", state, START);
                else
                    chk("R6 feedback step", state, exp_s);
                if ($countones(exp_s) == 1) seen_legal = 1'b1;
                #1;
            end
            chk("R7 legal within N", {31'd0, seen_legal}, 32'd1);
            chk("R7 one-hot after N", $countones(state), 1);
            for (int k = 0; k < N; k++) begin
                step();
                exp_s = model_next(exp_s);
                chk("R7 follows cycle", state, exp_s);
            end
        end

        // random enable and reset traffic
        rst = 1'b1;
        en  = 1'b0;
        step();
        exp_s = START;
        for (int i = 0; i < 400; i++) begin
            rst = ($urandom_range(0, 19) == 0);
            en  = ($urandom_range(0, 3) != 0);
            #1;
            chk("R8 random wrap", wrap, model_wrap(rst, en, exp_s));
            step();
            if (rst)      exp_s = START;
            else if (en)  exp_s = model_next(exp_s);
            chk("R2 R3 R4 random state", state, exp_s);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule